// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit carries out 32-bit atomic memory instructions on behalf of a RV32 core. The core hands it a decoded instruction (opcode, funct3, funct7, destination index, the address taken from rs1 and the operand taken from rs2). The unit checks that the instruction belongs to the atomic group. It reads the addressed word through a single-port word memory interface and combines it with the operand. It writes the result back and then reports the old word as the destination-register result.

A load-reserved operation records a reservation on one word. A later store-conditional writes only while that reservation still covers its word. A snoop input carries ordinary stores from elsewhere in the core, and a snoop that lands on the reserved word cancels the reservation. The controller is a four-state machine:
- ST_IDLE accepts a request. It moves to ST_READ for read-modify-write and load-reserved requests, to ST_WRITE for a store-conditional that holds a live reservation, and to ST_DONE for a store-conditional without one. An illegal request stays in ST_IDLE and raises the illegal flag.
- ST_READ waits for `mem_ready`, then moves to ST_DONE for a load-reserved and to ST_WRITE otherwise.
- ST_WRITE waits for `mem_ready`, then moves to ST_DONE.
- ST_DONE presents the result for one cycle and returns to ST_IDLE.

Top module: `amo_unit`

## Requirements
- R1: A request with `req_valid` is handled only while `busy` is low. Opcode 7'h2F with funct3 3'h2 is atomic, and the operation code is funct7[6:2]. The legal codes are ADD 5'h00, SWAP 5'h01, LR 5'h02, SC 5'h03, XOR 5'h04, OR 5'h08, AND 5'h0C, MIN 5'h10, MAX 5'h14, MINU 5'h18 and MAXU 5'h1C. Opcode 7'h2F with any other funct3, or with any other code, raises `illegal` for exactly one cycle, starting the cycle after acceptance. That request makes no memory access and produces no result.
- R2: funct7[1:0] never changes which operation is performed.
- R3: ADD, XOR, AND, OR and SWAP return the word that was in memory before the update. They write back old+rs2 (modulo 2^32), old^rs2, old&rs2, old|rs2 or rs2 respectively.
- R4: MIN and MAX write the smaller or larger of the old word and rs2, compared as signed two's-complement values. MINU and MAXU write the smaller or larger, compared as unsigned values. All four return the old word.
- R5: LR returns the addressed word, performs no write, and records a reservation on address bits [31:2].
- R6: SC succeeds only while the reservation is valid for the same bits [31:2]. On success it writes rs2 and returns 0. On failure it returns 1 and makes no memory access. Every SC clears the reservation.
- R7: A `snoop_valid` pulse whose address bits [31:2] match the reserved word clears the reservation. A snoop to another word leaves it intact.
- R8: `mem_req` stays high in the read and write phases until `mem_ready`, and `mem_we` is high only in the write phase. The result is reported for exactly one cycle, and `busy` is low again on the following cycle.
- R9: A result aimed at register 0 never raises `rd_valid`, but its memory update still happens.
- R10: `mem_addr` is word aligned, with bits [1:0] zero. `mem_addr` and `mem_we` stay stable while a memory request waits for `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Decoded instruction present |
| req_opcode | input | 7 | Major opcode |
| req_funct3 | input | 3 | funct3 field |
| req_funct7 | input | 7 | funct7 field |
| req_rd | input | 5 | Destination register index |
| req_addr | input | 32 | Address from rs1 |
| req_rs2 | input | 32 | Operand from rs2 |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ready | input | 1 | Memory access completes this cycle |
| snoop_valid | input | 1 | An ordinary store is observed |
| snoop_addr | input | 32 | Address of the observed store |
| rd_valid | output | 1 | Destination result valid (one cycle) |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 32 | Destination result |
| illegal | output | 1 | Illegal atomic instruction pulse |

## Verification
The bench targets the value 32'h80000000 against an operand of 1. There a signed/unsigned mix-up in MIN, MAX, MINU or MAXU writes the wrong winner. An ADD on 32'hFFFFFFFF checks that the sum wraps. Load-reserved and store-conditional pairs use different byte offsets within one word and then different words. That exposes a reservation compared on the full address, a store-conditional that fails to clear the reservation, and a snoop match that is ignored or too broad. Illegal funct3 and operation codes, set ordering bits, and destination register 0 show whether a bad decode touches memory, whether ordering bits alter the operation, and whether a result reaches register 0.

// File: rtl/amo_pkg.sv
package amo_pkg;
    localparam logic [6:0] AMO_OPCODE = 7'h2F;
    localparam logic [2:0] AMO_F3_WORD = 3'h2;

    typedef enum logic [4:0] {
        OP_ADD  = 5'h00,
        OP_SWAP = 5'h01,
        OP_LR   = 5'h02,
        OP_SC   = 5'h03,
        OP_XOR  = 5'h04,
        OP_OR   = 5'h08,
        OP_AND  = 5'h0C,
        OP_MIN  = 5'h10,
        OP_MAX  = 5'h14,
        OP_MINU = 5'h18,
        OP_MAXU = 5'h1C
    } amo_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } amo_state_e;
endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic [6:0] funct7,
    output logic       is_group,
    output logic       legal,
    output amo_op_e    op
);
    logic known;
    logic unused_order_bits;

    // ordering hints carry no meaning for operation selection
    assign unused_order_bits = ^funct7[1:0];

    always_comb begin
        op    = amo_op_e'(funct7[6:2]);
        known = 1'b0;
        case (funct7[6:2])
            OP_ADD, OP_SWAP, OP_LR, OP_SC, OP_XOR, OP_OR, OP_AND,
            OP_MIN, OP_MAX, OP_MINU, OP_MAXU: known = 1'b1;
            default: known = 1'b0;
        endcase
    end

    assign is_group = (opcode == AMO_OPCODE);
    assign legal    = is_group && (funct3 == AMO_F3_WORD) && known;
endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  amo_op_e             op,
    input  logic [XLEN-1:0]     old_word,
    input  logic [XLEN-1:0]     operand,
    output logic [XLEN-1:0]     new_word
);
    logic s_lt;
    logic u_lt;

    assign s_lt = $signed(old_word) < $signed(operand);
    assign u_lt = old_word < operand;

    always_comb begin
        case (op)
            OP_ADD:  new_word = old_word + operand;
            OP_XOR:  new_word = old_word ^ operand;
            OP_AND:  new_word = old_word & operand;
            OP_OR:   new_word = old_word | operand;
            OP_MIN:  new_word = s_lt ? old_word : operand;
            OP_MAX:  new_word = s_lt ? operand : old_word;
            OP_MINU: new_word = u_lt ? old_word : operand;
            OP_MAXU: new_word = u_lt ? operand : old_word;
            default: new_word = operand; // SWAP and SC store the operand as is
        endcase
    end
endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
    parameter int WAW = 30
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_en,
    input  logic [WAW-1:0] set_word,
    input  logic           clr_en,
    input  logic           snoop_valid,
    input  logic [WAW-1:0] snoop_word,
    input  logic [WAW-1:0] chk_word,
    output logic           hit
);
    logic           valid_q;
    logic [WAW-1:0] word_q;
    logic           snoop_kill;

    assign snoop_kill = snoop_valid && (snoop_word == word_q);
    assign hit        = valid_q && (chk_word == word_q) && !snoop_kill;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            word_q  <= '0;
        end else if (set_en) begin
            valid_q <= !(snoop_valid && (snoop_word == set_word));
            word_q  <= set_word;
        end else if (clr_en || snoop_kill) begin
            valid_q <= 1'b0;
        end
    end

    assert_sc_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !valid_q);

    assert_snoop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid && valid_q && snoop_word == word_q && !set_en) |=> !valid_q);
endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [6:0]      req_opcode,
    input  logic [2:0]      req_funct3,
    input  logic [6:0]      req_funct7,
    input  logic [4:0]      req_rd,
    input  logic [XLEN-1:0] req_addr,
    input  logic [XLEN-1:0] req_rs2,
    output logic            busy,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_ready,
    input  logic            snoop_valid,
    input  logic [XLEN-1:0] snoop_addr,
    output logic            rd_valid,
    output logic [4:0]      rd_idx,
    output logic [XLEN-1:0] rd_data,
    output logic            illegal
);
    localparam int WAW = XLEN - 2;

    amo_state_e     state_q, state_d;
    amo_op_e        op_q;
    logic [WAW-1:0] addr_q;
    logic [XLEN-1:0] rs2_q;
    logic [XLEN-1:0] result_q;
    logic [4:0]     rd_q;
    logic           illegal_q;

    logic           dec_group, dec_legal;
    amo_op_e        dec_op;
    logic           accept, start, sc_hit;
    logic [XLEN-1:0] alu_out;
    logic           unused_low_bits;

    assign unused_low_bits = ^{req_addr[1:0], snoop_addr[1:0]};

    amo_decode u_dec (
        .opcode  (req_opcode),
        .funct3  (req_funct3),
        .funct7  (req_funct7),
        .is_group(dec_group),
        .legal   (dec_legal),
        .op      (dec_op)
    );

    amo_alu #(.XLEN(XLEN)) u_alu (
        .op      (op_q),
        .old_word(result_q),
        .operand (rs2_q),
        .new_word(alu_out)
    );

    amo_resv #(.WAW(WAW)) u_resv (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (state_q == ST_READ && mem_ready && op_q == OP_LR),
        .set_word   (addr_q),
        .clr_en     (start && dec_op == OP_SC),
        .snoop_valid(snoop_valid),
        .snoop_word (snoop_addr[XLEN-1:2]),
        .chk_word   (req_addr[XLEN-1:2]),
        .hit        (sc_hit)
    );

    assign accept = (state_q == ST_IDLE) && req_valid && dec_group;
    assign start  = accept && dec_legal;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (dec_op == OP_SC) state_d = sc_hit ? ST_WRITE : ST_DONE;
                    else                 state_d = ST_READ;
                end
            end
            ST_READ:  if (mem_ready) state_d = (op_q == OP_LR) ? ST_DONE : ST_WRITE;
            ST_WRITE: if (mem_ready) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // captured request and result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= OP_ADD;
            addr_q    <= '0;
            rs2_q     <= '0;
            rd_q      <= '0;
            result_q  <= '0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= accept && !dec_legal;
            if (start) begin
                op_q   <= dec_op;
                addr_q <= req_addr[XLEN-1:2];
                rs2_q  <= req_rs2;
                rd_q   <= req_rd;
                if (dec_op == OP_SC)
                    result_q <= sc_hit ? '0 : XLEN'(1);
            end else if (state_q == ST_READ && mem_ready) begin
                result_q <= mem_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
        mem_we    = (state_q == ST_WRITE);
        mem_addr  = {addr_q, 2'b00};
        mem_wdata = alu_out;
        rd_valid  = (state_q == ST_DONE) && (rd_q != 5'd0);
        rd_idx    = rd_q;
        rd_data   = result_q;
        illegal   = illegal_q;
    end

    assert_illegal_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_req && !rd_valid));

    assert_result_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> (!rd_valid && !busy));

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_no_x0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_idx != 5'd0));
endmodule

// File: tb/amo_unit_tb_top.sv
module amo_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [6:0]  req_opcode = '0;
    logic [2:0]  req_funct3 = '0;
    logic [6:0]  req_funct7 = '0;
    logic [4:0]  req_rd = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_rs2 = '0;
    logic        busy, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        snoop_valid = 1'b0;
    logic [31:0] snoop_addr = '0;
    logic        rd_valid, illegal;
    logic [4:0]  rd_idx;
    logic [31:0] rd_data;

    always #2 clk = ~clk; // 250 MHz

    amo_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
        .req_funct3(req_funct3), .req_funct7(req_funct7), .req_rd(req_rd),
        .req_addr(req_addr), .req_rs2(req_rs2), .busy(busy), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .snoop_valid(snoop_valid),
        .snoop_addr(snoop_addr), .rd_valid(rd_valid), .rd_idx(rd_idx),
        .rd_data(rd_data), .illegal(illegal)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit summary_done = 0;

    logic [31:0] mem [16];
    logic [31:0] ref_mem [16];
    bit          ref_rv = 0;
    logic [29:0] ref_rw = '0;

    // memory responder: random latency, one-cycle ready pulse
    logic        wr_pend = 0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_dat = '0;
    always @(negedge clk) begin
        if (mem_ready) begin
            if (wr_pend) mem[wr_idx] = wr_dat;
            mem_ready = 1'b0;
            wr_pend   = 0;
        end else if (mem_req && ($urandom % 3 == 0)) begin
            mem_ready = 1'b1;
            mem_rdata = mem[mem_addr[5:2]];
            wr_pend   = mem_we;
            wr_idx    = mem_addr[5:2];
            wr_dat    = mem_wdata;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_new(input logic [4:0] op, input logic [31:0] o,
                                              input logic [31:0] b);
        case (op)
            5'h00: return o + b;
            5'h04: return o ^ b;
            5'h0C: return o & b;
            5'h08: return o | b;
            5'h10: return ($signed(o) < $signed(b)) ? o : b;
            5'h14: return ($signed(o) > $signed(b)) ? o : b;
            5'h18: return (o < b) ? o : b;
            5'h1C: return (o > b) ? o : b;
            default: return b;
        endcase
    endfunction

    function automatic bit known_op(input logic [4:0] op);
        case (op)
            5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h08, 5'h0C,
            5'h10, 5'h14, 5'h18, 5'h1C: return 1;
            default: return 0;
        endcase
    endfunction

    task automatic run_op(input logic [6:0] opc, input logic [2:0] f3, input logic [6:0] f7,
                          input logic [4:0] rd, input logic [31:0] addr,
                          input logic [31:0] rs2, input string tag);
        logic [4:0]  op = f7[6:2];
        int          idx = addr[5:2];
        bit          ours = (opc == 7'h2F);
        bit          legal = ours && f3 == 3'h2 && known_op(op);
        bit          touch = 0;
        logic [31:0] exp_res = '0;
        bit saw_v = 0, saw_ill = 0, saw_mem = 0, saw_we = 0;
        logic [31:0] got = '0;
        if (legal) begin
            if (op == 5'h02) begin
                exp_res = ref_mem[idx]; ref_rv = 1; ref_rw = addr[31:2]; touch = 1;
            end else if (op == 5'h03) begin
                if (ref_rv && ref_rw == addr[31:2]) begin
                    exp_res = 0; ref_mem[idx] = rs2; touch = 1;
                end else exp_res = 1;
                ref_rv = 0;
            end else begin
                exp_res = ref_mem[idx]; ref_mem[idx] = model_new(op, ref_mem[idx], rs2); touch = 1;
            end
        end
        @(negedge clk);
        req_valid = 1; req_opcode = opc; req_funct3 = f3; req_funct7 = f7;
        req_rd = rd; req_addr = addr; req_rs2 = rs2;
        @(negedge clk);
        req_valid = 0;
        for (int i = 0; i < 100; i++) begin
            if (i > 0) @(negedge clk);
            if (mem_req) saw_mem = 1;
            if (mem_we) saw_we = 1;
            if (rd_valid) begin saw_v = 1; got = rd_data; end
            if (illegal) saw_ill = 1;
            if (!busy) break;
        end
        check({tag, " illegal flag"}, 32'(saw_ill), 32'(ours && !legal));
        check({tag, " result valid"}, 32'(saw_v), 32'(legal && rd != 0));
        if (legal && rd != 0) check({tag, " result"}, got, exp_res);
        check({tag, " memory word"}, mem[idx], ref_mem[idx]);
        if (!touch) check({tag, " no memory access"}, 32'(saw_mem), 0);
        if (legal && op == 5'h02) check({tag, " LR no write R5"}, 32'(saw_we), 0);
    endtask

    task automatic snoop(input logic [31:0] a);
        @(negedge clk);
        snoop_valid = 1; snoop_addr = a;
        @(negedge clk);
        snoop_valid = 0;
        if (ref_rv && ref_rw == a[31:2]) ref_rv = 0;
    endtask

    task automatic set_word(input int i, input logic [31:0] v);
        mem[i] = v; ref_mem[i] = v;
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_A70C));
        for (int i = 0; i < 16; i++) set_word(i, $urandom);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R8 reset busy", 32'(busy), 0);
        check("R8 reset mem_req", 32'(mem_req), 0);
        check("R8 reset rd_valid", 32'(rd_valid), 0);
        check("R1 reset illegal", 32'(illegal), 0);

        // R3: add wraps
        set_word(1, 32'hFFFF_FFFF);
        run_op(7'h2F, 3'h2, {5'h00, 2'b00}, 5'd3, 32'h4, 32'h1, "R3 add wrap");
        run_op(7'h2F, 3'h2, {5'h01, 2'b00}, 5'd4, 32'h4, 32'hCAFE_0001, "R3 swap");
        // R4: signed versus unsigned
        set_word(2, 32'h8000_0000);
        run_op(7'h2F, 3'h2, {5'h10, 2'b00}, 5'd5, 32'h8, 32'h1, "R4 min");
        set_word(2, 32'h8000_0000);
        run_op(7'h2F, 3'h2, {5'h18, 2'b00}, 5'd5, 32'h8, 32'h1, "R4 minu");
        set_word(2, 32'h8000_0000);
        run_op(7'h2F, 3'h2, {5'h14, 2'b00}, 5'd5, 32'h8, 32'h1, "R4 max");
        set_word(2, 32'h8000_0000);
        run_op(7'h2F, 3'h2, {5'h1C, 2'b00}, 5'd5, 32'h8, 32'h1, "R4 maxu");
        // R2: ordering bits set
        run_op(7'h2F, 3'h2, {5'h0C, 2'b11}, 5'd6, 32'hC, 32'h0F0F_0F0F, "R2 and ordered");
        run_op(7'h2F, 3'h2, {5'h08, 2'b10}, 5'd6, 32'hC, 32'h1000_0000, "R2 or ordered");
        // R1: illegal and foreign encodings
        run_op(7'h2F, 3'h3, {5'h00, 2'b00}, 5'd7, 32'h10, 32'h5, "R1 bad funct3");
        run_op(7'h2F, 3'h2, {5'h05, 2'b00}, 5'd7, 32'h10, 32'h5, "R1 bad code");
        run_op(7'h33, 3'h2, {5'h00, 2'b00}, 5'd7, 32'h10, 32'h5, "R1 other opcode");
        // R9: destination x0
        run_op(7'h2F, 3'h2, {5'h04, 2'b00}, 5'd0, 32'h14, 32'hFFFF_0000, "R9 xor to x0");
        // R6: SC without reservation
        run_op(7'h2F, 3'h2, {5'h03, 2'b00}, 5'd8, 32'h18, 32'h1234, "R6 sc no resv");
        // R5/R6: LR then SC to another byte of the same word
        run_op(7'h2F, 3'h2, {5'h02, 2'b00}, 5'd8, 32'h18, 32'h0, "R5 lr");
        run_op(7'h2F, 3'h2, {5'h03, 2'b01}, 5'd9, 32'h1A, 32'hBEEF, "R6 sc same word");
        run_op(7'h2F, 3'h2, {5'h03, 2'b00}, 5'd9, 32'h18, 32'hDEAD, "R6 sc after clear");
        // R6: different word
        run_op(7'h2F, 3'h2, {5'h02, 2'b00}, 5'd8, 32'h1C, 32'h0, "R5 lr b");
        run_op(7'h2F, 3'h2, {5'h03, 2'b00}, 5'd9, 32'h20, 32'h77, "R6 sc other word");
        // R7: snoop hit and miss
        run_op(7'h2F, 3'h2, {5'h02, 2'b00}, 5'd8, 32'h24, 32'h0, "R5 lr c");
        snoop(32'h27);
        run_op(7'h2F, 3'h2, {5'h03, 2'b00}, 5'd9, 32'h24, 32'h55, "R7 sc after snoop hit");
        run_op(7'h2F, 3'h2, {5'h02, 2'b00}, 5'd8, 32'h24, 32'h0, "R5 lr d");
        snoop(32'h28);
        run_op(7'h2F, 3'h2, {5'h03, 2'b00}, 5'd9, 32'h24, 32'h66, "R7 sc after snoop miss");

        // random mix (R3, R4, R5, R6, R8, R10)
        for (int n = 0; n < 400; n++) begin
            logic [4:0]  ops [11] = '{5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h08,
                                      5'h0C, 5'h10, 5'h14, 5'h18, 5'h1C};
            logic [4:0]  op = ops[$urandom % 11];
            logic [31:0] a = 32'($urandom % 64);
            if (op == 5'h03 && ref_rv && ($urandom % 2 == 0))
                a = {ref_rw, 2'(($urandom % 4))};
            if ($urandom % 20 == 0) snoop(32'($urandom % 64));
            run_op(7'h2F, ($urandom % 25 == 0) ? 3'h1 : 3'h2,
                   {($urandom % 30 == 0) ? 5'h1F : op, 2'($urandom % 4)},
                   5'($urandom % 32), a, $urandom, "R8 random");
        end
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule